// File: doc/BRIEF.md
# Black-Level Clamp Loop Controller

This block is the digital half of a black-level correction loop for an image sensor front end. Each line carries a window of shielded pixels, flagged by the `clamp_win` input. While the window is open, the block compares every converter sample with a programmed black target. It sums the differences over the window and divides the sum by the pixel count to get the mean error. That mean is scaled down by a programmable loop gain and pulls a correction word toward the value that nulls the offset. The correction word drives an offset DAC at the converter input.

The target register has 8 bits and counts quarter converter LSBs, so it spans 0 to 63.75 LSB. A commit can be made after every window or after 2, 4 or 8 windows. In that slower mode, the errors of all windows in the period are pooled into one mean. When the loop is turned off, the output simply repeats the target register as a fixed offset. When the loop is turned back on, it starts from that offset.

Top module: `blackclamp_loop`

## Requirements
- R1: While `rst` is high, `dac_code` is 0. After reset with `loop_en` low, `dac_code` shows the clamp level.
- R2: While `loop_en` is low, `dac_code` equals `clamp_level`, zero-extended, from the next clock edge on. Windows and samples have no effect on it.
- R3: Errors are gathered only on clock edges where `clamp_win` and `loop_en` are both high. The error for one pixel is 4·`adc_data` − `clamp_level`.
- R4: A commit happens when a window closes (a high-to-low transition of `clamp_win`). Its mean error is the pooled error sum divided by the pooled pixel count, truncated toward zero. The new `dac_code` appears within 30 cycles of the window's falling edge, and `dac_code` does not change at any other time while the loop is enabled.
- R5: The step is the mean error arithmetically shifted right by `loop_gain` (0 to 7). The new correction is the old correction minus the step.
- R6: The correction saturates at 0 and at 1023 and never wraps.
- R7: `rate_sel` = n commits once every 2^n windows (n = 0 to 3). The errors of all windows in the period are pooled, and windows that do not commit leave `dac_code` unchanged.
- R8: A commit that has pooled zero pixels leaves `dac_code` unchanged.
- R9: A window of a single pixel is measured and committed like a longer one.
- R10: When `loop_en` rises, the loop starts from the clamp-level offset, with the window count of the period at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| clamp_win | input | 1 | High during the shielded-pixel window |
| adc_data | input | 10 | Converter sample, unsigned |
| clamp_level | input | 8 | Black target in quarter LSB; static offset when the loop is off |
| loop_en | input | 1 | Loop enable |
| rate_sel | input | 2 | Commit once every 2^rate_sel windows |
| loop_gain | input | 3 | Right-shift applied to the mean error |
| dac_code | output | 10 | Correction word for the offset DAC |

## Verification
The main sweep runs windows of 1, 3, 20 and 33 pixels with four sample shapes: flat, rising ramp, alternating high/low and scattered. It covers three targets and four loop gains. Flat and ramp windows with the same mean must give the same step, which separates averaging from summing or from taking the last sample. The alternating and scattered shapes produce negative and odd sums, which exposes truncation toward zero and arithmetic-shift errors. Further runs drive the correction into both rails, try every rate setting, close a window that has no counted pixels, and toggle samples and windows while the loop is off.

// File: rtl/blackclamp_pkg.sv
package blackclamp_pkg;

    localparam int ADC_W   = 10;
    localparam int FRAC_W  = 2;
    localparam int LVL_W   = 8;
    localparam int DAC_W   = 10;
    localparam int CNT_W   = 12;
    localparam int GAIN_W  = 3;
    localparam int RATE_W  = 2;

    localparam int ERR_W   = ADC_W + FRAC_W + 1;
    localparam int SUM_W   = ERR_W + CNT_W;
    localparam int WIDE_W  = ((ERR_W > DAC_W) ? ERR_W : DAC_W) + 2;
    localparam int WCNT_W  = (2 ** RATE_W) - 1;
    localparam int CTR_W   = $clog2(SUM_W);
    localparam int DAC_MAX = (2 ** DAC_W) - 1;

    typedef logic signed [ERR_W-1:0]  err_t;
    typedef logic signed [SUM_W-1:0]  sum_t;
    typedef logic signed [WIDE_W-1:0] wide_t;
    typedef logic [CNT_W-1:0]         cnt_t;
    typedef logic [DAC_W-1:0]         dac_t;

    typedef struct packed {
        logic valid;
        sum_t sum;
        cnt_t cnt;
    } period_t;

    typedef enum logic [1:0] {
        DIV_IDLE = 2'd0,
        DIV_RUN  = 2'd1,
        DIV_DONE = 2'd2
    } div_state_e;

    function automatic err_t pixel_error(logic [ADC_W-1:0] s, logic [LVL_W-1:0] t);
        err_t scaled;
        err_t target;
        scaled = err_t'({1'b0, s, {FRAC_W{1'b0}}});
        target = err_t'({{(ERR_W-LVL_W){1'b0}}, t});
        return scaled - target;
    endfunction

    function automatic dac_t level_to_dac(logic [LVL_W-1:0] t);
        return dac_t'({{(DAC_W-LVL_W){1'b0}}, t});
    endfunction

    function automatic dac_t clamp_to_dac(wide_t v);
        if (v < 0)
            return '0;
        else if (v > wide_t'(DAC_MAX))
            return dac_t'(DAC_MAX);
        else
            return v[DAC_W-1:0];
    endfunction

    function automatic logic [SUM_W-1:0] magnitude(sum_t v);
        return (v < 0) ? SUM_W'(-v) : SUM_W'(v);
    endfunction

endpackage

// File: rtl/bc_window_accum.sv
module bc_window_accum
    import blackclamp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              loop_en,
    input  logic              win_i,
    input  logic [ADC_W-1:0]  sample_i,
    input  logic [LVL_W-1:0]  level_i,
    input  logic [RATE_W-1:0] rate_i,
    output period_t           req_o
);

    logic              win_q;
    sum_t              sum_q;
    cnt_t              cnt_q;
    logic [WCNT_W-1:0] wcnt_q;
    logic [WCNT_W-1:0] last_idx;
    logic              end_evt;
    logic              last_win;
    err_t              px_err;

    always_comb begin
        last_idx = '0;
        for (int b = 0; b < WCNT_W; b++) begin
            if (b < int'(rate_i))
                last_idx[b] = 1'b1;
        end
    end

    assign px_err   = pixel_error(sample_i, level_i);
    assign end_evt  = win_q && !win_i && loop_en;
    assign last_win = (wcnt_q == last_idx);

    always_ff @(posedge clk) begin
        if (rst)
            win_q <= 1'b0;
        else
            win_q <= win_i;
    end

    always_ff @(posedge clk) begin
        if (rst || !loop_en) begin
            sum_q  <= '0;
            cnt_q  <= '0;
            wcnt_q <= '0;
            req_o  <= '0;
        end else begin
            req_o.valid <= 1'b0;
            if (win_i) begin
                sum_q <= sum_q + sum_t'(px_err);
                cnt_q <= cnt_q + cnt_t'(1);
            end else if (end_evt) begin
                if (last_win) begin
                    req_o.valid <= 1'b1;
                    req_o.sum   <= sum_q;
                    req_o.cnt   <= cnt_q;
                    sum_q       <= '0;
                    cnt_q       <= '0;
                    wcnt_q      <= '0;
                end else begin
                    wcnt_q <= wcnt_q + WCNT_W'(1);
                end
            end
        end
    end

    // pixel count frozen outside the window (R3)
    assert_count_outside_window_R3: assert property (@(posedge clk) disable iff (rst)
        (loop_en && !win_i && !end_evt) |=> $stable(cnt_q));

    // a request never follows a cycle with the loop off (R2)
    assert_no_request_when_off_R2: assert property (@(posedge clk) disable iff (rst)
        !loop_en |=> !req_o.valid);

endmodule

// File: rtl/bc_seq_divider.sv
module bc_seq_divider
    import blackclamp_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    abort_i,
    input  period_t req_i,
    output logic    done_o,
    output err_t    mean_o
);

    div_state_e        st_q;
    logic [SUM_W-1:0]  dvd_q;
    logic [CNT_W-1:0]  rem_q;
    cnt_t              dsr_q;
    logic              neg_q;
    logic [CTR_W-1:0]  ctr_q;
    logic [CNT_W:0]    rem_sh;
    logic              qbit;
    logic [CNT_W:0]    rem_next;
    logic [SUM_W-1:0]  q_full;

    assign rem_sh   = {rem_q, dvd_q[SUM_W-1]};
    assign qbit     = (rem_sh >= {1'b0, dsr_q});
    assign rem_next = qbit ? (rem_sh - {1'b0, dsr_q}) : rem_sh;
    assign q_full   = neg_q ? (~dvd_q + SUM_W'(1)) : dvd_q;
    assign mean_o   = err_t'(q_full[ERR_W-1:0]);
    assign done_o   = (st_q == DIV_DONE);

    always_ff @(posedge clk) begin
        if (rst || abort_i) begin
            st_q  <= DIV_IDLE;
            dvd_q <= '0;
            rem_q <= '0;
            dsr_q <= '0;
            neg_q <= 1'b0;
            ctr_q <= '0;
        end else begin
            unique case (st_q)
                DIV_IDLE: begin
                    if (req_i.valid && (req_i.cnt != '0)) begin
                        dvd_q <= magnitude(req_i.sum);
                        neg_q <= (req_i.sum < 0);
                        dsr_q <= req_i.cnt;
                        rem_q <= '0;
                        ctr_q <= '0;
                        st_q  <= DIV_RUN;
                    end
                end
                DIV_RUN: begin
                    rem_q <= rem_next[CNT_W-1:0];
                    dvd_q <= {dvd_q[SUM_W-2:0], qbit};
                    ctr_q <= ctr_q + CTR_W'(1);
                    if (ctr_q == CTR_W'(SUM_W - 1))
                        st_q <= DIV_DONE;
                end
                DIV_DONE: st_q <= DIV_IDLE;
                default:  st_q <= DIV_IDLE;
            endcase
        end
    end

    // an empty period never starts a division (R8)
    assert_empty_period_skipped_R8: assert property (@(posedge clk) disable iff (rst)
        (st_q == DIV_IDLE && req_i.valid && req_i.cnt == '0 && !abort_i) |=> (st_q == DIV_IDLE));

    // result is a single-cycle pulse (R4)
    assert_done_single_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // remainder always below divisor while running (R4)
    assert_remainder_bound_R4: assert property (@(posedge clk) disable iff (rst)
        (st_q == DIV_RUN) |-> ({1'b0, rem_q} < {1'b0, dsr_q}));

endmodule

// File: rtl/bc_correction.sv
module bc_correction
    import blackclamp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              loop_en,
    input  logic [LVL_W-1:0]  level_i,
    input  logic [GAIN_W-1:0] gain_i,
    input  logic              done_i,
    input  err_t              mean_i,
    output dac_t              corr_o
);

    err_t  step;
    wide_t diff;

    assign step = mean_i >>> gain_i;
    assign diff = wide_t'({{(WIDE_W-DAC_W){1'b0}}, corr_o}) - wide_t'(step);

    always_ff @(posedge clk) begin
        if (rst)
            corr_o <= '0;
        else if (!loop_en)
            corr_o <= level_to_dac(level_i);
        else if (done_i)
            corr_o <= clamp_to_dac(diff);
    end

    // correction only moves on a commit while enabled (R4)
    assert_hold_between_commits_R4: assert property (@(posedge clk) disable iff (rst)
        (loop_en && !done_i) |=> $stable(corr_o));

    // disabled loop presents the static offset (R2)
    assert_static_offset_R2: assert property (@(posedge clk) disable iff (rst)
        !loop_en |=> (corr_o == level_to_dac($past(level_i))));

    // top rail holds under a raising step (R6)
    assert_top_rail_R6: assert property (@(posedge clk) disable iff (rst)
        (loop_en && done_i && corr_o == dac_t'(DAC_MAX) && mean_i < 0) |=> (corr_o == dac_t'(DAC_MAX)));

    // bottom rail holds under a lowering step (R6)
    assert_bottom_rail_R6: assert property (@(posedge clk) disable iff (rst)
        (loop_en && done_i && corr_o == '0 && mean_i > 0) |=> (corr_o == '0));

endmodule

// File: rtl/blackclamp_loop.sv
module blackclamp_loop
    import blackclamp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clamp_win,
    input  logic [ADC_W-1:0]  adc_data,
    input  logic [LVL_W-1:0]  clamp_level,
    input  logic              loop_en,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic [GAIN_W-1:0] loop_gain,
    output logic [DAC_W-1:0]  dac_code
);

    period_t period_req;
    logic    mean_done;
    err_t    mean_err;
    dac_t    corr;

    bc_window_accum u_accum (
        .clk      (clk),
        .rst      (rst),
        .loop_en  (loop_en),
        .win_i    (clamp_win),
        .sample_i (adc_data),
        .level_i  (clamp_level),
        .rate_i   (rate_sel),
        .req_o    (period_req)
    );

    bc_seq_divider u_div (
        .clk     (clk),
        .rst     (rst),
        .abort_i (!loop_en),
        .req_i   (period_req),
        .done_o  (mean_done),
        .mean_o  (mean_err)
    );

    bc_correction u_corr (
        .clk     (clk),
        .rst     (rst),
        .loop_en (loop_en),
        .level_i (clamp_level),
        .gain_i  (loop_gain),
        .done_i  (mean_done),
        .mean_i  (mean_err),
        .corr_o  (corr)
    );

    assign dac_code = corr;

    // reset state visible at the output (R1)
    assert_reset_zero_R1: assert property (@(posedge clk)
        $past(rst) |-> (dac_code == '0));

endmodule

// File: tb/blackclamp_loop_bench.sv
module blackclamp_loop_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       clamp_win;
    logic [9:0] adc_data;
    logic [7:0] clamp_level;
    logic       loop_en;
    logic [1:0] rate_sel;
    logic [2:0] loop_gain;
    logic [9:0] dac_code;

    int vectors = 0;
    int misses  = 0;
    int m_corr, m_sum, m_cnt, m_win;

    always #10 clk = ~clk;

    blackclamp_loop u_blackclamp_loop (
        .clk(clk), .rst(rst), .clamp_win(clamp_win), .adc_data(adc_data),
        .clamp_level(clamp_level), .loop_en(loop_en), .rate_sel(rate_sel),
        .loop_gain(loop_gain), .dac_code(dac_code)
    );

    task automatic check(string req, int exp);
        vectors++;
        if (int'(dac_code) != exp) begin
            misses++;
            $display("FAIL %s: dac_code=%0d expected=%0d", req, dac_code, exp);
        end
    endtask

    function automatic int shape(int kind, int i, int base);
        int v;
        case (kind)
            0: v = base;
            1: v = base + i;
            2: v = (i % 2 == 1) ? base + 50 : ((base >= 50) ? base - 50 : 0);
            default: v = (base * 7 + i * 13) % 1024;
        endcase
        return v % 1024;
    endfunction

    task automatic go_disabled(int lvl);
        @(negedge clk);
        loop_en = 1'b0; clamp_level = 8'(lvl);
        @(negedge clk);
        m_corr = lvl; m_sum = 0; m_cnt = 0; m_win = 0;
    endtask

    task automatic go_enabled(string req);
        @(negedge clk);
        loop_en = 1'b1;
        @(negedge clk);
        check(req, m_corr);
    endtask

    task automatic run_window(string req, int len, int kind, int base);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            clamp_win = 1'b1;
            adc_data = 10'(shape(kind, i, base));
            if (loop_en) begin
                m_sum += 4 * shape(kind, i, base) - int'(clamp_level);
                m_cnt++;
            end
        end
        @(negedge clk);
        clamp_win = 1'b0;
        repeat (40) @(negedge clk);
        if (loop_en) begin
            m_win++;
            if (m_win == (1 << rate_sel)) begin
                m_win = 0;
                if (m_cnt > 0) begin
                    int avg, stp;
                    avg = m_sum / m_cnt;
                    stp = avg >>> loop_gain;
                    m_corr = m_corr - stp;
                    if (m_corr < 0) m_corr = 0;
                    if (m_corr > 1023) m_corr = 1023;
                end
                m_sum = 0; m_cnt = 0;
            end
        end
        check(req, m_corr);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        misses++;
        $display("FAIL watchdog: dac_code=%0d expected=run complete", dac_code);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        rst = 1'b1; clamp_win = 1'b0; adc_data = '0; clamp_level = 8'd37;
        loop_en = 1'b0; rate_sel = '0; loop_gain = '0;
        repeat (3) @(negedge clk);
        check("R1 reset", 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", 37);
        m_corr = 37; m_sum = 0; m_cnt = 0; m_win = 0;

        // R2: windows ignored while off, level change followed next edge
        run_window("R2 ignored window", 10, 0, 900);
        clamp_level = 8'd201;
        @(negedge clk);
        m_corr = 201;
        check("R2 level follow", 201);
        run_window("R2 ignored ramp", 25, 1, 3);

        // R3 R4 R5 R9 sweep
        for (int g = 0; g < 4; g++) begin
            for (int t = 0; t < 3; t++) begin
                int lv;
                lv = (t == 0) ? 0 : ((t == 1) ? 100 : 255);
                go_disabled(lv);
                loop_gain = 3'(g); rate_sel = 2'd0;
                go_enabled("R10 start offset");
                for (int k = 0; k < 4; k++) begin
                    for (int l = 0; l < 4; l++) begin
                        int len;
                        len = (l == 0) ? 1 : ((l == 1) ? 3 : ((l == 2) ? 20 : 33));
                        run_window((len == 1) ? "R9 single pixel" : "R3 R4 R5 mean step",
                                   len, k, (len * 31 + k * 97 + g * 11) % 120);
                    end
                end
            end
        end

        // R6 rails
        go_disabled(255); loop_gain = 3'd0; rate_sel = 2'd0;
        go_enabled("R10 start offset");
        for (int w = 0; w < 5; w++) run_window("R6 top rail", 20, 0, 0);
        check("R6 top rail held", 1023);
        go_disabled(0);
        go_enabled("R10 start offset");
        run_window("R6 bottom rail", 20, 0, 1000);
        check("R6 bottom rail held", 0);

        // R7 rate divider
        for (int r = 1; r < 4; r++) begin
            go_disabled(120); loop_gain = 3'd1; rate_sel = 2'(r);
            go_enabled("R10 start offset");
            for (int w = 0; w < (2 << r); w++)
                run_window("R7 pooled period", 5, w % 4, 10 + w * 20);
        end

        // R8 empty period
        go_disabled(90); rate_sel = 2'd0; loop_gain = 3'd0;
        @(negedge clk); clamp_win = 1'b1; adc_data = 10'd700;
        repeat (3) @(negedge clk);
        loop_en = 1'b1; clamp_win = 1'b0;
        repeat (40) @(negedge clk);
        check("R8 empty commit", 90);
        run_window("R8 next window", 4, 0, 30);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule